// File: doc/BRIEF.md
# Configurable Two-Generator Logic Cell

This block models one programmable logic cell. It holds two independent 4-input function generators, each defined by a 16-entry truth table, and a flip-flop behind each one. After configuration, the X generator computes any Boolean function of its own four inputs and the Y generator computes any function of its own four inputs, with no link between them. Each generator's result reaches its cell output either directly or through its flip-flop, chosen per output.

The truth tables and three mode bits are loaded serially through a one-bit configuration port while the load enable is high. The X table goes in first, then the Y table, then the mode bits. A done flag reports a complete load. In combine mode, a 2-to-1 multiplexer steered by an extra select input picks between the two generator results. The cell then realizes any 5-input function by Shannon expansion on that select. The Y output keeps its ordinary function in this mode.

Both flip-flops share a clock enable and a synchronous active-high reset. The generator width is a parameter, and the table and configuration lengths follow from it.

Top module: `dual_lut_cell`

## Requirements
- R1: While `cfg_en` is high, each rising edge shifts `cfg_bit` into a 35-bit chain (for the default width of 4). The first bit shifted becomes X table entry 0, which is the output for X input combination 0000. The next 15 bits fill X entries 1 to 15, the following 16 bits fill Y entries 0 to 15, and the last three bits are, in order, X bypass, Y bypass and combine enable.
- R2: `cfg_done` is 0 after reset and during any rising edge with `cfg_en` high. It becomes 1 on the edge after the last configuration bit, provided `cfg_en` is then low.
- R3: With X bypass set to 1 and combine disabled, `x_out` equals X table entry `x_in` with no clock delay.
- R4: With Y bypass set to 1, `y_out` equals Y table entry `y_in`, independent of `x_in`.
- R5: With bypass set to 0, an output shows its generator result as sampled at the last rising edge that had `ce` high.
- R6: With `ce` low, the registered outputs hold their value while the inputs change.
- R7: A rising edge with `rst` high clears both flip-flops to 0, so the registered outputs read 0.
- R8: With combine set to 1, `x_out` is Y table entry `y_in` when `sel` is 1 and X table entry `x_in` when `sel` is 0. It is registered or not according to X bypass. `y_out` is unaffected by `sel`.
- R9: While `cfg_en` is low, `cfg_bit` has no effect on the loaded configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of flip-flops and load tracking |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_done | output | 1 | Configuration complete flag |
| ce | input | 1 | Shared flip-flop clock enable |
| x_in | input | 4 | X generator inputs |
| y_in | input | 4 | Y generator inputs |
| sel | input | 1 | Combine-mode select: 1 picks Y, 0 picks X |
| x_out | output | 1 | X cell output |
| y_out | output | 1 | Y cell output |

## Verification
The bench builds the cell with its default 4-input generators. This makes all 16 input combinations per generator, and all 32 combinations of the 5-variable combine mode, small enough to sweep exhaustively against tables chosen to be asymmetric, so that a reversed or shifted bit order shows up as a miscompare. The 35-bit load is short enough to repeat for every mode mix, including registered combine mode and a load with the clock enable held low.

// File: rtl/dual_lut_cell.sv
module dual_lut_cell #(
  parameter int K = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_en,
  input  logic         cfg_bit,
  output logic         cfg_done,
  input  logic         ce,
  input  logic [K-1:0] x_in,
  input  logic [K-1:0] y_in,
  input  logic         sel,
  output logic         x_out,
  output logic         y_out
);
  localparam int TB  = 1 << K;
  localparam int NB  = 2 * TB + 3;
  localparam int CW  = $clog2(NB + 1);

  logic [NB-1:0] cfg_sr;
  logic [CW-1:0] cnt;
  logic [TB-1:0] xtab, ytab;
  logic          xbyp, ybyp, comb;
  logic          fx, fy, x_fn;
  logic          x_q, y_q;

  always_ff @(posedge clk)
    if (cfg_en) cfg_sr <= {cfg_bit, cfg_sr[NB-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      cfg_done <= 1'b0;
    end else if (cfg_en) begin
      cnt      <= (cnt == CW'(NB)) ? CW'(1) : cnt + CW'(1);
      cfg_done <= 1'b0;
    end else begin
      cfg_done <= (cnt == CW'(NB));
    end
  end

  assign xtab = cfg_sr[TB-1:0];
  assign ytab = cfg_sr[2*TB-1:TB];
  assign xbyp = cfg_sr[2*TB];
  assign ybyp = cfg_sr[2*TB+1];
  assign comb = cfg_sr[2*TB+2];

  assign fx   = xtab[x_in];
  assign fy   = ytab[y_in];
  assign x_fn = (comb && sel) ? fy : fx;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q <= 1'b0;
      y_q <= 1'b0;
    end else if (ce) begin
      x_q <= x_fn;
      y_q <= fy;
    end
  end

  assign x_out = xbyp ? x_fn : x_q;
  assign y_out = ybyp ? fy : y_q;

  a_r2_done_low_in_load: assert property (@(posedge clk) disable iff (rst)
    cfg_en |=> !cfg_done);
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_sr));
  a_r6_hold_without_ce: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(x_q) && $stable(y_q)));
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (!x_q && !y_q));
  a_r5_y_capture: assert property (@(posedge clk) disable iff (rst)
    ce |=> (y_q == $past(ytab[y_in])));
endmodule

// File: tb/dual_lut_cell_test.sv
module dual_lut_cell_test;
  logic clk = 0, rst = 1, cfg_en = 0, cfg_bit = 0, ce = 0, sel = 0;
  logic [3:0] x_in = 0, y_in = 0;
  logic cfg_done, x_out, y_out;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  dual_lut_cell uut (.clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
    .cfg_done(cfg_done), .ce(ce), .x_in(x_in), .y_in(y_in), .sel(sel),
    .x_out(x_out), .y_out(y_out));

  task automatic chk(string req, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic load(logic [15:0] xt, logic [15:0] yt, logic xb, logic yb, logic cb);
    logic [34:0] v;
    v = {cb, yb, xb, yt, xt};
    for (int i = 0; i < 35; i++) begin
      @(negedge clk);
      cfg_en = 1; cfg_bit = v[i];
      if (i == 20) chk("R2 done low mid-load", cfg_done, 1'b0);
    end
    @(negedge clk);
    chk("R2 done low right after last bit edge", cfg_done, 1'b0);
    cfg_en = 0; cfg_bit = 0;
    @(negedge clk);
    chk("R2 done high one cycle after load", cfg_done, 1'b1);
  endtask

  task automatic t_comb_sweep(logic [15:0] xt, logic [15:0] yt);
    load(xt, yt, 1, 1, 0);
    for (int i = 0; i < 16; i++) begin
      x_in = 4'(i); y_in = 4'(15 - i); sel = i[0];
      #1;
      chk("R1 R3 X unregistered table entry", x_out, xt[i]);
      chk("R4 Y independent table entry", y_out, yt[15 - i]);
    end
  endtask

  task automatic t_registered(logic [15:0] xt, logic [15:0] yt);
    load(xt, yt, 0, 0, 0);
    ce = 1;
    x_in = 4'd3; y_in = 4'd12;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      logic ex, ey;
      ex = xt[x_in]; ey = yt[y_in];
      x_in = 4'(i); y_in = 4'(i ^ 5);
      #1;
      chk("R5 X output held until edge", x_out, ex);
      @(negedge clk);
      chk("R5 X registered one cycle", x_out, xt[i]);
      chk("R5 Y registered one cycle", y_out, yt[i ^ 5]);
    end
  endtask

  task automatic t_ce_hold(logic [15:0] xt, logic [15:0] yt);
    logic hx, hy;
    hx = x_out; hy = y_out;
    ce = 0;
    for (int i = 0; i < 16; i++) begin
      x_in = 4'(i); y_in = 4'(i);
      @(negedge clk);
      chk("R6 X held with ce low", x_out, hx);
      chk("R6 Y held with ce low", y_out, hy);
    end
    ce = 1;
    @(negedge clk);
    chk("R6 X resumes with ce", x_out, xt[15]);
    chk("R6 Y resumes with ce", y_out, yt[15]);
  endtask

  task automatic t_reset();
    x_in = 4'd0; y_in = 4'd0; ce = 1;
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R7 X flop cleared", x_out, 1'b0);
    chk("R7 Y flop cleared", y_out, 1'b0);
    chk("R2 done cleared by reset", cfg_done, 1'b0);
    ce = 0;
    @(negedge clk);
  endtask

  task automatic t_combine(logic [15:0] xt, logic [15:0] yt);
    load(xt, yt, 1, 1, 1);
    for (int i = 0; i < 32; i++) begin
      sel = i[4]; x_in = 4'(i); y_in = 4'(i * 3);
      #1;
      chk("R8 combined X result", x_out, i[4] ? yt[4'(i * 3)] : xt[4'(i)]);
      chk("R8 Y unaffected by sel", y_out, yt[4'(i * 3)]);
      @(negedge clk);
    end
    load(xt, yt, 0, 1, 1);
    ce = 1;
    sel = 1; x_in = 4'd0; y_in = 4'd4;
    @(negedge clk);
    chk("R8 registered combine picks Y", x_out, yt[4]);
    sel = 0; x_in = 4'd1;
    @(negedge clk);
    chk("R8 registered combine picks X", x_out, xt[1]);
    ce = 0;
  endtask

  task automatic t_ignore(logic [15:0] xt, logic [15:0] yt);
    load(xt, yt, 1, 1, 0);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      cfg_bit = ~cfg_bit;
    end
    chk("R9 done still high", cfg_done, 1'b1);
    for (int i = 0; i < 16; i++) begin
      x_in = 4'(i); y_in = 4'(i); sel = 1;
      #1;
      chk("R9 X table unchanged", x_out, xt[i]);
      chk("R9 Y table unchanged", y_out, yt[i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R2 done low after reset", cfg_done, 1'b0);
    rst = 0;
    t_comb_sweep(16'hA5C3, 16'h1234);
    t_comb_sweep(16'h0001, 16'h8000);
    t_registered(16'h6996, 16'h3C0F);
    t_ce_hold(16'h6996, 16'h3C0F);
    t_reset();
    t_combine(16'h00F1, 16'hE817);
    t_ignore(16'h5A0F, 16'hC6B2);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule